// File: doc/BRIEF.md
# Console Service Call Trap

This block sits beside a small 8-bit processor core and watches its instruction fetch address. A fetch from the service entry address (0x0005) is treated as a console system call. The block reads the function code and the 16-bit pointer register pair through a register snoop port, and then services the call in hardware. The processor sees a plain return opcode stored at that entry address, so it simply returns from the call once the block releases it.

Two services exist. The first puts one character on the output stream: the low byte of the pointer pair. The second prints a string. It reads bytes from memory, starting at the pointer and moving upward, and forwards each byte until it reads a dollar sign. While a call is being serviced, the block asserts a hold output that stalls the core.

A fetch from address 0x0000 means the program has asked for a warm boot. The block then latches a done status and ignores everything after it. A fetch from any other address below 0x0100, which is where programs are loaded and start, latches an illegal-access flag. A call with an unknown function code latches an unsupported-function flag.

FSM states: `ST_IDLE` waits for a fetch. `ST_RD_REQ` issues one memory read. `ST_RD_WAIT` inspects the returned byte. `ST_EMIT` offers a byte on the output stream. `ST_STOP` is the final state after a warm boot.

The transitions are:
- `ST_IDLE`→`ST_RD_REQ` on a string call.
- `ST_IDLE`→`ST_EMIT` on a character call.
- `ST_IDLE`→`ST_STOP` on a warm-boot fetch.
- `ST_RD_REQ`→`ST_RD_WAIT` always.
- `ST_RD_WAIT`→`ST_IDLE` when the byte is the terminator.
- `ST_RD_WAIT`→`ST_EMIT` otherwise.
- `ST_EMIT`→`ST_RD_REQ` when a string byte is accepted.
- `ST_EMIT`→`ST_IDLE` when a single character is accepted.

Top module: `con_svc_trap`

## Requirements
- R1: After reset, cpu_hold, mem_rd_en, out_valid, boot_done, bad_entry and bad_func are all 0.
- R2: A fetch of 0x0005 with svc_fn equal to 0x02 or 0x05 emits exactly one byte, equal to svc_ptr[7:0], and sets no flag.
- R3: A fetch of 0x0005 with svc_fn equal to 0x09 reads memory at svc_ptr, svc_ptr+1, and so on. Every byte before the first 0x24 is emitted in order. The 0x24 byte is read but not emitted, and no further read follows it.
- R4: A fetch of 0x0005 with any other svc_fn sets bad_func, which stays set until reset. No byte is emitted, no read is issued and the hold is not raised.
- R5: A fetch of 0x0000 sets boot_done, which stays set until reset. After that, no fetch causes a read, an output byte or a hold.
- R6: A fetch of any address from 0x0001 to 0x00FF other than 0x0005 sets bad_entry, which stays set until reset. Fetches at 0x0100 and above cause no action.
- R7: cpu_hold is 1 from the cycle after an accepted service call until the service ends. It returns to 0 the cycle after the terminator is read, or after the single character is accepted. Every read and every offered byte occurs while cpu_hold is 1.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable. The next memory read is issued only after the current byte has been accepted.
- R9: The string read address wraps from 0xFFFF to 0x0000.
- R10: With pc_valid at 0, the block takes no action, whatever value pc_addr holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | Instruction fetch strobe from the core |
| pc_addr | input | 16 | Fetch address |
| svc_fn | input | 8 | Snooped function-code register |
| svc_ptr | input | 16 | Snooped pointer register pair; low byte is the character |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after mem_rd_en |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Output sink ready |
| cpu_hold | output | 1 | Stall request to the core |
| boot_done | output | 1 | Warm boot seen (sticky) |
| bad_entry | output | 1 | Illegal low-memory fetch (sticky) |
| bad_func | output | 1 | Unsupported function code (sticky) |

## Verification
The bench sweeps all 256 function codes at the entry address, and all fetch addresses from 0x000 to 0x1FF. This catches a decoder that accepts a wrong code, or one that flags the entry address or an address at or above 0x0100. Strings are walked across the top of the address space, which exposes an address that carries out or saturates instead of wrapping. An empty string is also walked, which exposes a terminator that gets emitted. Throttled and stalled output readiness catches a walker that skips, repeats or reads ahead of acceptance. A trap after warm boot, and a fetch without a strobe, catch a block that keeps acting when it should be inert.

// File: rtl/cst_pkg.sv
package cst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_EMIT,
        ST_STOP
    } cst_state_e;

    typedef enum logic [1:0] {
        PCK_NONE,
        PCK_ENTRY,
        PCK_BOOT,
        PCK_ILLEGAL
    } pc_kind_e;

    typedef enum logic [1:0] {
        SVC_CHAR,
        SVC_STR,
        SVC_BADFN
    } svc_kind_e;

endpackage

// File: rtl/cst_decode.sv
module cst_decode
    import cst_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ENTRY_PC  = 'h0005,
    parameter logic [AW-1:0] BOOT_PC   = 'h0000,
    parameter logic [AW-1:0] LOW_LIMIT = 'h0100,
    parameter logic [DW-1:0] FN_STR    = 'h09,
    parameter int N_CHR_FN = 2,
    parameter logic [N_CHR_FN*DW-1:0] FN_CHR_LIST = {8'h05, 8'h02}
) (
    input  logic          pc_valid,
    input  logic [AW-1:0] pc_addr,
    input  logic [DW-1:0] fn_code,
    output pc_kind_e      pc_kind,
    output svc_kind_e     svc_kind
);

    logic [N_CHR_FN-1:0] chr_hit;

    generate
        for (genvar gi = 0; gi < N_CHR_FN; gi++) begin : g_chr
            assign chr_hit[gi] = (fn_code == FN_CHR_LIST[gi*DW +: DW]);
        end
    endgenerate

    always_comb begin
        if (!pc_valid)
            pc_kind = PCK_NONE;
        else if (pc_addr == ENTRY_PC)
            pc_kind = PCK_ENTRY;
        else if (pc_addr == BOOT_PC)
            pc_kind = PCK_BOOT;
        else if (pc_addr < LOW_LIMIT)
            pc_kind = PCK_ILLEGAL;
        else
            pc_kind = PCK_NONE;
    end

    always_comb begin
        if (fn_code == FN_STR)
            svc_kind = SVC_STR;
        else if (|chr_hit)
            svc_kind = SVC_CHAR;
        else
            svc_kind = SVC_BADFN;
    end

endmodule

// File: rtl/cst_walk_addr.sv
module cst_walk_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step)
            addr <= addr + AW'(1);
    end

endmodule

// File: rtl/cst_ctrl.sv
module cst_ctrl
    import cst_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] TERM_CHAR = 'h24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_kind_e      pc_kind,
    input  svc_kind_e     svc_kind,
    input  logic [DW-1:0] char_in,
    input  logic [DW-1:0] rd_data,
    input  logic          out_ready,
    output logic          addr_load,
    output logic          addr_step,
    output logic          cpu_hold,
    output logic          mem_rd_en,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          boot_done,
    output logic          bad_entry,
    output logic          bad_func
);

    cst_state_e    state_q, state_d;
    logic [DW-1:0] byte_q;
    logic          is_str_q;
    logic          take_call;

    assign take_call = (state_q == ST_IDLE) && (pc_kind == PCK_ENTRY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pc_kind == PCK_BOOT)
                    state_d = ST_STOP;
                else if (take_call && svc_kind == SVC_STR)
                    state_d = ST_RD_REQ;
                else if (take_call && svc_kind == SVC_CHAR)
                    state_d = ST_EMIT;
            end
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: state_d = (rd_data == TERM_CHAR) ? ST_IDLE : ST_EMIT;
            ST_EMIT: begin
                if (out_ready)
                    state_d = is_str_q ? ST_RD_REQ : ST_IDLE;
            end
            ST_STOP:    state_d = ST_STOP;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            byte_q    <= '0;
            is_str_q  <= 1'b0;
            bad_entry <= 1'b0;
            bad_func  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_call) begin
                is_str_q <= (svc_kind == SVC_STR);
                if (svc_kind == SVC_CHAR)
                    byte_q <= char_in;
                if (svc_kind == SVC_BADFN)
                    bad_func <= 1'b1;
            end
            if (state_q == ST_IDLE && pc_kind == PCK_ILLEGAL)
                bad_entry <= 1'b1;
            if (state_q == ST_RD_WAIT)
                byte_q <= rd_data;
        end
    end

    always_comb begin
        cpu_hold  = (state_q == ST_RD_REQ) || (state_q == ST_RD_WAIT) || (state_q == ST_EMIT);
        mem_rd_en = (state_q == ST_RD_REQ);
        out_valid = (state_q == ST_EMIT);
        out_data  = byte_q;
        boot_done = (state_q == ST_STOP);
        addr_load = take_call && (svc_kind == SVC_STR);
        addr_step = (state_q == ST_EMIT) && out_ready && is_str_q;
    end

endmodule

// File: rtl/con_svc_trap.sv
module con_svc_trap #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ENTRY_PC  = 'h0005,
    parameter logic [AW-1:0] BOOT_PC   = 'h0000,
    parameter logic [AW-1:0] LOW_LIMIT = 'h0100,
    parameter logic [DW-1:0] TERM_CHAR = 'h24,
    parameter logic [DW-1:0] FN_STR    = 'h09,
    parameter logic [DW-1:0] FN_CHR_A  = 'h02,
    parameter logic [DW-1:0] FN_CHR_B  = 'h05
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_valid,
    input  logic [AW-1:0] pc_addr,
    input  logic [DW-1:0] svc_fn,
    input  logic [AW-1:0] svc_ptr,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    output logic          cpu_hold,
    output logic          boot_done,
    output logic          bad_entry,
    output logic          bad_func
);

    import cst_pkg::*;

    localparam int N_CHR_FN = 2;
    localparam logic [N_CHR_FN*DW-1:0] CHR_LIST = {FN_CHR_B, FN_CHR_A};

    pc_kind_e  pc_kind;
    svc_kind_e svc_kind;
    logic      addr_load;
    logic      addr_step;

    cst_decode #(
        .AW(AW), .DW(DW),
        .ENTRY_PC(ENTRY_PC), .BOOT_PC(BOOT_PC), .LOW_LIMIT(LOW_LIMIT),
        .FN_STR(FN_STR), .N_CHR_FN(N_CHR_FN), .FN_CHR_LIST(CHR_LIST)
    ) u_dec (
        .pc_valid (pc_valid),
        .pc_addr  (pc_addr),
        .fn_code  (svc_fn),
        .pc_kind  (pc_kind),
        .svc_kind (svc_kind)
    );

    cst_walk_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (svc_ptr),
        .step     (addr_step),
        .addr     (mem_rd_addr)
    );

    cst_ctrl #(.DW(DW), .TERM_CHAR(TERM_CHAR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_kind   (pc_kind),
        .svc_kind  (svc_kind),
        .char_in   (svc_ptr[DW-1:0]),
        .rd_data   (mem_rd_data),
        .out_ready (out_ready),
        .addr_load (addr_load),
        .addr_step (addr_step),
        .cpu_hold  (cpu_hold),
        .mem_rd_en (mem_rd_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .boot_done (boot_done),
        .bad_entry (bad_entry),
        .bad_func  (bad_func)
    );

endmodule

// File: rtl/cst_chk.sv
module cst_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_hold,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_ready,
    input logic          boot_done,
    input logic          bad_entry,
    input logic          bad_func
);

    AST_VALID_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cpu_hold); // R7

    AST_READ_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> cpu_hold); // R7

    AST_EMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_NO_READ_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && out_valid)); // R8

    AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en && $stable(mem_rd_addr))); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> (boot_done && !cpu_hold)); // R5

    AST_FUNC_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_func |=> bad_func); // R4

    AST_ENTRY_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_entry |=> bad_entry); // R6

endmodule

bind con_svc_trap cst_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_hold    (cpu_hold),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .boot_done   (boot_done),
    .bad_entry   (bad_entry),
    .bad_func    (bad_func)
);

// File: tb/sim_con_svc_trap.sv
`timescale 1ns/1ps
module sim_con_svc_trap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_valid = 1'b0;
    logic [15:0] pc_addr = '0;
    logic [7:0]  svc_fn = '0;
    logic [15:0] svc_ptr = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        cpu_hold, boot_done, bad_entry, bad_func;

    always #2.5 clk = ~clk;

    con_svc_trap u0 (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_addr(pc_addr),
        .svc_fn(svc_fn), .svc_ptr(svc_ptr), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .cpu_hold(cpu_hold), .boot_done(boot_done), .bad_entry(bad_entry),
        .bad_func(bad_func)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int rcnt = 0;
    logic first_hold;

    logic [7:0]  mem [0:255];
    logic [7:0]  got_b [0:63];
    logic [15:0] got_a [0:63];
    int n_b = 0;
    int n_a = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[7:0]];
            if (n_a < 64) got_a[n_a] <= mem_rd_addr;
            n_a <= n_a + 1;
        end
        if (out_valid && out_ready) begin
            if (n_b < 64) got_b[n_b] <= out_data;
            n_b <= n_b + 1;
        end
    end

    always @(negedge clk) begin
        rcnt++;
        out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (rcnt % 3 == 0) : 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_a = 0;
        n_b = 0;
    endtask

    task automatic run_trap(input logic [15:0] pc, input logic [7:0] fn, input logic [15:0] ptr);
        int g;
        n_a = 0;
        n_b = 0;
        @(negedge clk);
        pc_valid = 1'b1;
        pc_addr = pc;
        svc_fn = fn;
        svc_ptr = ptr;
        @(negedge clk);
        pc_valid = 1'b0;
        first_hold = cpu_hold;
        g = 0;
        while (cpu_hold && g < 3000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
    endtask

    task automatic load_str(input logic [7:0] base, input string s);
        for (int i = 0; i < s.len(); i++) mem[8'(base + i)] = s[i];
        mem[8'(base + s.len())] = 8'h24;
    endtask

    task automatic chk_str(input logic [15:0] ptr, input string s, input string req);
        chk(n_b == s.len(), req, n_b, s.len());
        chk(n_a == s.len() + 1, req, n_a, s.len() + 1);
        for (int i = 0; i < s.len() && i < 64; i++)
            chk(got_b[i] == s[i], req, got_b[i], s[i]);
        for (int i = 0; i <= s.len() && i < 64; i++)
            chk(got_a[i] == 16'(ptr + i), {req, "/R9"}, got_a[i], 16'(ptr + i));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h41;
        load_str(8'h40, "Hi!");

        do_reset();
        // R1 reset state
        chk({cpu_hold, mem_rd_en, out_valid, boot_done, bad_entry, bad_func} == 6'b0,
            "R1", {cpu_hold, mem_rd_en, out_valid, boot_done, bad_entry, bad_func}, 0);

        // R2 R3 R4 R7: sweep every function code at the entry address
        for (int f = 0; f < 256; f++) begin
            do_reset();
            run_trap(16'h0005, 8'(f), 16'h0140);
            if (f == 2 || f == 5) begin
                chk(n_b == 1 && got_b[0] == 8'h40, "R2", got_b[0], 8'h40);
                chk(bad_func == 1'b0 && n_a == 0, "R2", bad_func, 0);
                chk(first_hold == 1'b1, "R7", first_hold, 1);
            end else if (f == 9) begin
                chk_str(16'h0140, "Hi!", "R3");
                chk(first_hold == 1'b1, "R7", first_hold, 1);
            end else begin
                chk(bad_func == 1'b1, "R4", bad_func, 1);
                chk(n_b == 0 && n_a == 0, "R4", n_b + n_a, 0);
                chk(first_hold == 1'b0, "R4", first_hold, 0);
            end
            chk(cpu_hold == 1'b0, "R7", cpu_hold, 0);
        end

        // R6 R5: sweep fetch addresses 0x000..0x1FF
        for (int p = 0; p < 512; p++) begin
            do_reset();
            run_trap(16'(p), 8'h02, 16'h0033);
            chk(bad_entry == (p < 256 && p != 5 && p != 0), "R6", bad_entry,
                (p < 256 && p != 5 && p != 0));
            chk(boot_done == (p == 0), "R5", boot_done, (p == 0));
            chk(n_b == (p == 5), "R6", n_b, (p == 5));
        end

        // R4 flag stays set across a later good call
        do_reset();
        run_trap(16'h0005, 8'h07, 16'h0140);
        run_trap(16'h0005, 8'h02, 16'h0040);
        chk(bad_func == 1'b1 && n_b == 1, "R4", bad_func, 1);

        // R5 after warm boot nothing acts
        do_reset();
        run_trap(16'h0000, 8'h09, 16'h0140);
        run_trap(16'h0005, 8'h09, 16'h0140);
        chk(n_a == 0 && n_b == 0 && first_hold == 1'b0, "R5", n_a + n_b, 0);
        chk(boot_done == 1'b1, "R5", boot_done, 1);

        // R9 wrap across top of address space
        do_reset();
        mem[8'hFE] = 8'h61; mem[8'hFF] = 8'h62; mem[8'h00] = 8'h63; mem[8'h01] = 8'h24;
        run_trap(16'h0005, 8'h09, 16'hFFFE);
        chk_str(16'hFFFE, "abc", "R9");

        // R3 empty string: terminator first
        run_trap(16'h0005, 8'h09, 16'h0143);
        chk(n_b == 0 && n_a == 1, "R3", n_b, 0);

        // R8 throttled sink
        rdy_mode = 1;
        run_trap(16'h0005, 8'h09, 16'h0140);
        chk_str(16'h0140, "Hi!", "R8");
        rdy_mode = 0;

        // R8 stalled sink: one read, byte held
        do_reset();
        rdy_mode = 2;
        n_a = 0; n_b = 0;
        @(negedge clk);
        pc_valid = 1'b1; pc_addr = 16'h0005; svc_fn = 8'h09; svc_ptr = 16'h0140;
        @(negedge clk);
        pc_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'h48, "R8", out_data, 8'h48);
        chk(n_a == 1 && cpu_hold == 1'b1, "R8", n_a, 1);
        rdy_mode = 0;
        repeat (20) @(negedge clk);
        chk(n_b == 3 && cpu_hold == 1'b0, "R8", n_b, 3);

        // R10 no strobe, no action
        do_reset();
        @(negedge clk);
        pc_valid = 1'b0; pc_addr = 16'h0005; svc_fn = 8'h09; svc_ptr = 16'h0140;
        repeat (5) @(negedge clk);
        chk(cpu_hold == 1'b0 && n_a == 0 && n_b == 0, "R10", cpu_hold, 0);
        pc_addr = 16'h0000;
        repeat (3) @(negedge clk);
        chk(boot_done == 1'b0 && bad_entry == 1'b0, "R10", boot_done, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule